// File: doc/BRIEF.md
# Drift-Trimmed Timestamp Counter

This block keeps a 16-bit timestamp for a node on a shared bus. Each enabled tick normally adds one to the count. The local oscillator can run slightly fast or slow compared with the other nodes, so the block applies a periodic trim. Once every programmed number of ticks, the tick that completes the period adds two instead of one, or adds nothing. A direction input chooses which of the two applies.

The counter restarts from a programmable base value, not from zero. It restarts in three cases: its own wrap past 16'hFFFF, a pulse from an external compare unit, and a pulse from an identifier matcher. A phase counter counts ticks since the last restart or the last trim. Every restart clears the phase counter, so trim points always line up with the start of a run.

Software writes the trim period and the base value through two write strobes. A new period is adopted only at a restart or at a trim point, so a period already running is never disturbed. One exception applies: while trimming is disabled (active period zero), a new value is adopted on the next cycle. The base value is read at each restart, so a new value is first used at the next restart.

Top module: `drift_stamp_timer`

## Requirements
- R1: After synchronous reset the count is 16'h0000, the overflow pulse is low, and the trim period and base value are both zero.
- R2: When `tick_en` is low and no clear pulse is present, the count does not change.
- R3: With an active trim period of zero, every enabled tick adds exactly one to the count.
- R4: With an active period P greater than zero and `trim_up` = 1, the P-th tick after each restart or trim point adds two. After k ticks from a restart with base B, the count is B + k + floor(k/P), modulo 2^16.
- R5: With an active period P greater than zero and `trim_up` = 0, the P-th tick after each restart or trim point leaves the count unchanged. After k ticks from a restart with base B, the count is B + k - floor(k/P), modulo 2^16.
- R6: A period write above 16'h8000 is stored as 16'h8000. After writing 16'hFFFF with `trim_up` = 0, base 0, and 32768 ticks, the count is 16'h7FFF.
- R7: A pulse on `cmp_clear` or `id_clear` loads the count with the base value and restarts the trim phase. The clear does not depend on `tick_en`.
- R8: A clear on the same cycle as a trim point takes priority. The trim is dropped, and the next trim comes P ticks after the clear.
- R9: A tick whose step (one or two) would carry past 16'hFFFF loads the count with the base value and raises `ovf` for exactly that one following cycle. The trim phase restarts at the same time.
- R10: A period written in the middle of a period becomes active only at the next trim point or restart. The current period completes with the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Advance the timestamp on this cycle |
| trim_up | input | 1 | Trim direction: 1 = step by two, 0 = hold |
| period_wr | input | 1 | Write strobe for the trim period |
| period_wdata | input | 16 | Trim period value, clamped to 16'h8000 |
| base_wr | input | 1 | Write strobe for the restart base value |
| base_wdata | input | 16 | Restart base value |
| cmp_clear | input | 1 | Single-cycle clear from a compare match |
| id_clear | input | 1 | Single-cycle clear from an identifier match |
| count | output | 16 | Current timestamp |
| ovf | output | 1 | One-cycle pulse after a wrap restart |

## Verification
Two situations are hard to reach from the ports. One is a clear that lands on the very tick that completes a trim period. The other is a period rewrite that arrives partway through a running period. The bench reaches both by first restarting the counter with a known period, then counting ticks exactly. It fires the clear or the write at a computed tick index and compares later counts with the closed-form expressions in R4 and R5. For the wrap-by-two case, it sets the base just below the top so that a period of one drives the carry within two ticks.

// File: rtl/dst_pkg.sv
package dst_pkg;
  typedef enum logic [1:0] {
    STEP_NONE = 2'd0,
    STEP_ONE  = 2'd1,
    STEP_TWO  = 2'd2
  } step_e;

  function automatic step_e pick_step(input logic trim_hit, input logic up);
    if (!trim_hit) return STEP_ONE;
    return up ? STEP_TWO : STEP_NONE;
  endfunction
endpackage

// File: rtl/dst_cfg.sv
module dst_cfg #(
  parameter int W          = 16,
  parameter int PERIOD_MAX = 32768
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         period_wr,
  input  logic [W-1:0] period_wdata,
  input  logic         base_wr,
  input  logic [W-1:0] base_wdata,
  input  logic         adopt,
  output logic [W-1:0] active_period,
  output logic [W-1:0] base_val
);
  localparam logic [W-1:0] CAP = W'(PERIOD_MAX);

  logic [W-1:0] pend_period;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_period   <= '0;
      active_period <= '0;
      base_val      <= '0;
    end else begin
      if (period_wr)
        pend_period <= (period_wdata > CAP) ? CAP : period_wdata;
      if (base_wr)
        base_val <= base_wdata;
      if (adopt)
        active_period <= pend_period;
    end
  end

  p_period_cap_r6: assert property (@(posedge clk) disable iff (rst)
    active_period <= CAP);
  p_adopt_only_r10: assert property (@(posedge clk) disable iff (rst)
    !adopt |=> $stable(active_period));
endmodule

// File: rtl/dst_phase.sv
module dst_phase #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick_en,
  input  logic         restart,
  input  logic [W-1:0] active_period,
  output logic         trim_hit,
  output logic         adopt
);
  logic [W-1:0] phase;
  logic         enabled;

  assign enabled  = (active_period != '0);
  assign trim_hit = tick_en && enabled && (phase == active_period - 1'b1);
  assign adopt    = restart || trim_hit || !enabled;

  always_ff @(posedge clk) begin
    if (rst)
      phase <= '0;
    else if (restart)
      phase <= '0;
    else if (tick_en && enabled)
      phase <= trim_hit ? '0 : phase + 1'b1;
  end

  p_phase_bound_r4: assert property (@(posedge clk) disable iff (rst)
    enabled |-> phase < active_period);
  p_restart_phase_r7: assert property (@(posedge clk) disable iff (rst)
    restart |=> phase == '0);
endmodule

// File: rtl/dst_count.sv
module dst_count #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick_en,
  input  logic         clear,
  input  logic         trim_hit,
  input  logic         trim_up,
  input  logic [W-1:0] base_val,
  output logic [W-1:0] count,
  output logic         ovf,
  output logic         restart
);
  import dst_pkg::*;

  step_e      step;
  logic [W:0] sum;
  logic       wrap;

  assign step    = pick_step(trim_hit, trim_up);
  assign sum     = {1'b0, count} + {{(W-1){1'b0}}, 2'(step)};
  assign wrap    = tick_en && sum[W];
  assign restart = clear || wrap;

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
      ovf   <= 1'b0;
    end else begin
      ovf <= 1'b0;
      if (clear)
        count <= base_val;
      else if (tick_en) begin
        if (wrap) begin
          count <= base_val;
          ovf   <= 1'b1;
        end else
          count <= sum[W-1:0];
      end
    end
  end

  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (!tick_en && !clear) |=> $stable(count));
  p_clear_load_r7: assert property (@(posedge clk) disable iff (rst)
    clear |=> count == $past(base_val));
  p_ovf_cause_r9: assert property (@(posedge clk) disable iff (rst)
    ovf |-> ($past(tick_en) && !$past(clear)));
  p_plain_step_r3: assert property (@(posedge clk) disable iff (rst)
    (tick_en && !clear && !trim_hit && !wrap) |=> count == $past(count) + 1'b1);
endmodule

// File: rtl/drift_stamp_timer.sv
module drift_stamp_timer #(
  parameter int W          = 16,
  parameter int PERIOD_MAX = 32768
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick_en,
  input  logic         trim_up,
  input  logic         period_wr,
  input  logic [W-1:0] period_wdata,
  input  logic         base_wr,
  input  logic [W-1:0] base_wdata,
  input  logic         cmp_clear,
  input  logic         id_clear,
  output logic [W-1:0] count,
  output logic         ovf
);
  logic [W-1:0] active_period;
  logic [W-1:0] base_val;
  logic         trim_hit;
  logic         adopt;
  logic         restart;
  logic         clear;

  assign clear = cmp_clear || id_clear;

  dst_cfg #(.W(W), .PERIOD_MAX(PERIOD_MAX)) u_cfg (
    .clk(clk), .rst(rst),
    .period_wr(period_wr), .period_wdata(period_wdata),
    .base_wr(base_wr), .base_wdata(base_wdata),
    .adopt(adopt),
    .active_period(active_period), .base_val(base_val)
  );

  dst_phase #(.W(W)) u_phase (
    .clk(clk), .rst(rst), .tick_en(tick_en), .restart(restart),
    .active_period(active_period), .trim_hit(trim_hit), .adopt(adopt)
  );

  dst_count #(.W(W)) u_count (
    .clk(clk), .rst(rst), .tick_en(tick_en), .clear(clear),
    .trim_hit(trim_hit), .trim_up(trim_up), .base_val(base_val),
    .count(count), .ovf(ovf), .restart(restart)
  );

  p_reset_state_r1: assert property (@(posedge clk)
    rst |=> (count == '0 && !ovf));
endmodule

// File: tb/test_drift_stamp_timer.sv
module test_drift_stamp_timer;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick_en = 1'b0;
  logic        trim_up = 1'b0;
  logic        period_wr = 1'b0;
  logic [15:0] period_wdata = '0;
  logic        base_wr = 1'b0;
  logic [15:0] base_wdata = '0;
  logic        cmp_clear = 1'b0;
  logic        id_clear = 1'b0;
  logic [15:0] count;
  logic        ovf;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  drift_stamp_timer i_drift_stamp_timer (
    .clk(clk), .rst(rst), .tick_en(tick_en), .trim_up(trim_up),
    .period_wr(period_wr), .period_wdata(period_wdata),
    .base_wr(base_wr), .base_wdata(base_wdata),
    .cmp_clear(cmp_clear), .id_clear(id_clear),
    .count(count), .ovf(ovf)
  );

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] model(input logic [15:0] b, input int k,
                                        input int p, input logic up);
    int v;
    v = int'(b) + k;
    if (p != 0) v = up ? v + k / p : v - k / p;
    return 16'(v);
  endfunction

  task automatic setup(input logic [15:0] p, input logic [15:0] b, input logic use_id);
    period_wr = 1'b1; period_wdata = p; base_wr = 1'b1; base_wdata = b;
    cyc();
    period_wr = 1'b0; base_wr = 1'b0;
    if (use_id) id_clear = 1'b1; else cmp_clear = 1'b1;
    cyc();
    cmp_clear = 1'b0; id_clear = 1'b0;
  endtask

  task automatic ticks(input int n);
    tick_en = 1'b1;
    repeat (n) cyc();
    tick_en = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 195000);
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) cyc();
    rst = 1'b0;
    cyc();
    chk("R1 count", count, 16'h0000);
    chk("R1 ovf", 16'(ovf), 16'h0000);

    // R3 / R4 / R5 sweep over small periods, both directions, both clear sources
    for (int p = 0; p <= 6; p++) begin
      for (int up = 0; up <= 1; up++) begin
        logic [15:0] b;
        b = 16'(16'h0100 * p + 16'h0011 * up);
        trim_up = up[0];
        setup(16'(p), b, up[0]);
        chk("R7 restart", count, b);
        for (int k = 1; k <= 20; k++) begin
          tick_en = 1'b1;
          cyc();
          chk(p == 0 ? "R3 plain" : (up == 1 ? "R4 trim up" : "R5 trim hold"),
              count, model(b, k, p, up[0]));
        end
        tick_en = 1'b0;
        // R2: no ticks, no change
        repeat (4) cyc();
        chk("R2 idle", count, model(b, 20, p, up[0]));
      end
    end

    // R7: clear without tick_en
    trim_up = 1'b1;
    setup(16'd3, 16'h2222, 1'b0);
    ticks(2);
    id_clear = 1'b1; cyc(); id_clear = 1'b0;
    chk("R7 id clear", count, 16'h2222);

    // R8: clear on the trim tick
    ticks(2);
    chk("R8 pre", count, 16'h2224);
    tick_en = 1'b1; cmp_clear = 1'b1; cyc();
    cmp_clear = 1'b0; tick_en = 1'b0;
    chk("R8 clear wins", count, 16'h2222);
    ticks(2);
    chk("R8 no early trim", count, 16'h2224);
    ticks(1);
    chk("R8 trim after P", count, 16'h2226);

    // R10: period rewrite mid-period
    setup(16'd4, 16'h3000, 1'b0);
    ticks(2);
    period_wr = 1'b1; period_wdata = 16'd2; cyc(); period_wr = 1'b0;
    ticks(2);
    chk("R10 old period kept", count, 16'h3005);
    ticks(2);
    chk("R10 new period", count, 16'h3008);

    // R9: wrap by one
    trim_up = 1'b0;
    setup(16'd0, 16'hFFFE, 1'b0);
    ticks(1);
    chk("R9 top", count, 16'hFFFF);
    chk("R9 no ovf", 16'(ovf), 16'h0000);
    ticks(1);
    chk("R9 wrap base", count, 16'hFFFE);
    chk("R9 ovf pulse", 16'(ovf), 16'h0001);
    cyc();
    chk("R9 ovf one cycle", 16'(ovf), 16'h0000);

    // R9: wrap by two
    trim_up = 1'b1;
    setup(16'd1, 16'hFFFD, 1'b1);
    ticks(1);
    chk("R9 step two", count, 16'hFFFF);
    ticks(1);
    chk("R9 wrap by two", count, 16'hFFFD);
    chk("R9 ovf by two", 16'(ovf), 16'h0001);

    // R6: oversize period clamps to 16'h8000
    trim_up = 1'b0;
    setup(16'hFFFF, 16'h0000, 1'b0);
    ticks(32767);
    chk("R6 before trim", count, 16'h7FFF);
    ticks(1);
    chk("R6 clamped trim", count, 16'h7FFF);
    ticks(1);
    chk("R6 after trim", count, 16'h8000);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule